// File: doc/BRIEF.md
# Three-Level Pin Trim Controller

This block holds a 7-bit trim code that is set from one control pin with three voltage bands. Three comparator flags report the pin's level: below the low threshold, above the high threshold, and above the programming threshold. The block classifies each sample into a mid, low, high or programming level. It then measures how long the pin stays there, using a 1 µs tick, and turns each qualified excursion into one step of the code. Low steps up and high steps down. Holding the pin in the programming band asks an external non-volatile store to keep the current code.

At power-up the block waits a boot interval and then copies the stored code into its counter. A count-enable input gates stepping. A write to the store is handled through a request/busy handshake, and no step or commit is taken while that write is in progress. Every time constant is a parameter counted in ticks.

Top module: `trim_pin_ctrl`

## Requirements
- R1: While `rst` is high, `code` is 0, `ready` is 0 and `nv_wr_req` is 0.
- R2: `LOAD_TICKS` ticks after reset is released, `code` takes the value on `nv_rd_data` and `ready` goes to 1. Before that, `ready` stays 0.
- R3: `code` is a 7-bit unsigned binary value. A low-level excursion held for at least `ACCEPT_TICKS` ticks raises it by exactly one. A high-level excursion held for that long lowers it by exactly one.
- R4: A low or high excursion shorter than `ACCEPT_TICKS` ticks leaves `code` unchanged.
- R5: At most one step is taken per excursion. The pin must return to the mid level before another step is possible, so moving from low straight to high gives only the first step.
- R6: `code` saturates: an up step at 127 keeps 127, and a down step at 0 keeps 0.
- R7: While `cnt_en` is 0, qualified excursions leave `code` unchanged.
- R8: A qualified excursion that completes fewer than `GAP_TICKS` ticks after the last accepted step is ignored.
- R9: Holding the programming level for `PROG_TICKS` ticks raises `nv_wr_req`, with `nv_wr_data` equal to `code`. The request stays high until `nv_busy` is seen, so the store receives the code that was current.
- R10: A programming-level excursion shorter than `PROG_TICKS` ticks raises no write request.
- R11: `wr_busy` is 1 from the write request until `nv_busy` falls. While it is 1, excursions leave `code` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle time-base strobe, nominally every 1 µs |
| pin_lo | input | 1 | Pin below the low threshold |
| pin_hi | input | 1 | Pin above the high threshold |
| pin_prog | input | 1 | Pin above the programming threshold |
| cnt_en | input | 1 | Count enable |
| nv_rd_data | input | 7 | Code held in non-volatile storage |
| nv_busy | input | 1 | Storage write in progress |
| code | output | 7 | Current trim code |
| ready | output | 1 | Boot load done |
| wr_busy | output | 1 | Commit in progress |
| nv_wr_req | output | 1 | Write request to storage |
| nv_wr_data | output | 7 | Code to be written |

## Verification
The hardest situation to reach from the ports is a second qualified excursion that lands inside the spacing window. With the default values, the width rule alone always keeps excursions further apart than the window. The bench therefore builds the block with a spacing window longer than the acceptance width. It then drives two full-width low excursions separated by only a brief return to mid, and a third one after a long rest. Only the first and the third may step.

A second hard case is an excursion made while a storage write is still running. The bench's storage model keeps `nv_busy` high for a long stretch, and the excursion is driven inside that stretch.

// File: rtl/trim_pkg.sv
package trim_pkg;

    typedef enum logic [1:0] {
        LVL_MID  = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_HIGH = 2'd2,
        LVL_PROG = 2'd3
    } pin_lvl_e;

    typedef enum logic [1:0] {
        NV_BOOT = 2'd0,
        NV_IDLE = 2'd1,
        NV_REQ  = 2'd2,
        NV_WAIT = 2'd3
    } nv_state_e;

    typedef struct packed {
        logic valid;
        logic inc;
    } step_req_t;

    function automatic pin_lvl_e classify(input logic lo, input logic hi, input logic prog);
        if (prog)
            return LVL_PROG;
        else if (lo)
            return LVL_LOW;
        else if (hi)
            return LVL_HIGH;
        else
            return LVL_MID;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/trim_level_sync.sv
module trim_level_sync
    import trim_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pin_lo,
    input  logic     pin_hi,
    input  logic     pin_prog,
    output pin_lvl_e level
);

    logic [2:0] stg [SYNC_STAGES];

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst)
                    stg[g] <= '0;
                else
                    stg[g] <= {pin_prog, pin_hi, pin_lo};
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst)
                    stg[g] <= '0;
                else
                    stg[g] <= stg[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            level <= LVL_MID;
        else
            level <= classify(stg[SYNC_STAGES-1][0],
                              stg[SYNC_STAGES-1][1],
                              stg[SYNC_STAGES-1][2]);
    end

endmodule

// File: rtl/trim_width_qual.sv
module trim_width_qual
    import trim_pkg::*;
#(
    parameter int unsigned ACCEPT_TICKS = 200,
    parameter int unsigned PROG_TICKS   = 200
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  pin_lvl_e  level,
    output step_req_t step_o,
    output logic      commit_o
);

    localparam int unsigned MAX_T = max_u(ACCEPT_TICKS, PROG_TICKS);
    localparam int unsigned CW    = $clog2(MAX_T + 1);
    localparam logic [CW-1:0] CNT_MAX  = CW'(MAX_T);
    localparam logic [CW-1:0] ACC_LAST = CW'(ACCEPT_TICKS - 1);
    localparam logic [CW-1:0] PRG_LAST = CW'(PROG_TICKS - 1);

    pin_lvl_e    prev_q;
    logic [CW-1:0] width_q;
    logic        armed_q;
    logic        prog_done_q;
    logic        is_swing;

    assign is_swing = (level == LVL_LOW) || (level == LVL_HIGH);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q      <= LVL_MID;
            width_q     <= '0;
            armed_q     <= 1'b1;
            prog_done_q <= 1'b0;
            step_o      <= '0;
            commit_o    <= 1'b0;
        end else begin
            step_o   <= '0;
            commit_o <= 1'b0;
            prev_q   <= level;
            if (level != prev_q) begin
                width_q     <= '0;
                prog_done_q <= 1'b0;
            end else if (tick) begin
                if (width_q != CNT_MAX)
                    width_q <= width_q + 1'b1;
                if (is_swing && armed_q && width_q == ACC_LAST) begin
                    step_o.valid <= 1'b1;
                    step_o.inc   <= (level == LVL_LOW);
                    armed_q      <= 1'b0;
                end
                if (level == LVL_PROG && !prog_done_q && width_q == PRG_LAST) begin
                    commit_o    <= 1'b1;
                    prog_done_q <= 1'b1;
                end
            end
            if (level == LVL_MID)
                armed_q <= 1'b1;
        end
    end

endmodule

// File: rtl/trim_code_reg.sv
module trim_code_reg
    import trim_pkg::*;
#(
    parameter int unsigned CODE_W    = 7,
    parameter int unsigned GAP_TICKS = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              load,
    input  logic [CODE_W-1:0] load_val,
    input  step_req_t         step,
    input  logic              allow,
    output logic [CODE_W-1:0] code
);

    localparam int unsigned GW = $clog2(GAP_TICKS + 1);
    localparam logic [GW-1:0] GAP_FULL = GW'(GAP_TICKS);
    localparam logic [CODE_W-1:0] CODE_TOP = '1;

    logic [GW-1:0] gap_q;
    logic          take;

    assign take = step.valid && allow && (gap_q == GAP_FULL);

    always_ff @(posedge clk) begin
        if (rst) begin
            code  <= '0;
            gap_q <= GAP_FULL;
        end else begin
            if (take)
                gap_q <= '0;
            else if (tick && gap_q != GAP_FULL)
                gap_q <= gap_q + 1'b1;

            if (load)
                code <= load_val;
            else if (take) begin
                if (step.inc && code != CODE_TOP)
                    code <= code + 1'b1;
                else if (!step.inc && code != '0)
                    code <= code - 1'b1;
            end
        end
    end

endmodule

// File: rtl/trim_nv_seq.sv
module trim_nv_seq
    import trim_pkg::*;
#(
    parameter int unsigned CODE_W     = 7,
    parameter int unsigned LOAD_TICKS = 500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              commit,
    input  logic [CODE_W-1:0] code,
    input  logic              nv_busy,
    output logic              load,
    output logic              ready,
    output logic              wr_busy,
    output logic              nv_wr_req,
    output logic [CODE_W-1:0] nv_wr_data
);

    localparam int unsigned BW = $clog2(LOAD_TICKS + 1);
    localparam logic [BW-1:0] BOOT_LAST = BW'(LOAD_TICKS - 1);

    nv_state_e     state_q;
    logic [BW-1:0] boot_q;

    assign load      = (state_q == NV_BOOT) && tick && (boot_q == BOOT_LAST);
    assign ready     = (state_q != NV_BOOT);
    assign wr_busy   = (state_q == NV_REQ) || (state_q == NV_WAIT);
    assign nv_wr_req = (state_q == NV_REQ);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= NV_BOOT;
            boot_q     <= '0;
            nv_wr_data <= '0;
        end else begin
            unique case (state_q)
                NV_BOOT: begin
                    if (load)
                        state_q <= NV_IDLE;
                    else if (tick)
                        boot_q <= boot_q + 1'b1;
                end
                NV_IDLE: begin
                    if (commit) begin
                        nv_wr_data <= code;
                        state_q    <= NV_REQ;
                    end
                end
                NV_REQ: begin
                    if (nv_busy)
                        state_q <= NV_WAIT;
                end
                NV_WAIT: begin
                    if (!nv_busy)
                        state_q <= NV_IDLE;
                end
                default: state_q <= NV_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/trim_pin_ctrl.sv
module trim_pin_ctrl
    import trim_pkg::*;
#(
    parameter int unsigned CODE_W       = 7,
    parameter int unsigned ACCEPT_TICKS = 200,
    parameter int unsigned PROG_TICKS   = 200,
    parameter int unsigned GAP_TICKS    = 10,
    parameter int unsigned LOAD_TICKS   = 500,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              pin_lo,
    input  logic              pin_hi,
    input  logic              pin_prog,
    input  logic              cnt_en,
    input  logic [CODE_W-1:0] nv_rd_data,
    input  logic              nv_busy,
    output logic [CODE_W-1:0] code,
    output logic              ready,
    output logic              wr_busy,
    output logic              nv_wr_req,
    output logic [CODE_W-1:0] nv_wr_data
);

    pin_lvl_e  level;
    step_req_t step;
    logic      commit;
    logic      load;
    logic      allow;

    assign allow = ready && !wr_busy && cnt_en;

    trim_level_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pin_lo   (pin_lo),
        .pin_hi   (pin_hi),
        .pin_prog (pin_prog),
        .level    (level)
    );

    trim_width_qual #(
        .ACCEPT_TICKS(ACCEPT_TICKS),
        .PROG_TICKS  (PROG_TICKS)
    ) u_qual (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .level    (level),
        .step_o   (step),
        .commit_o (commit)
    );

    trim_code_reg #(
        .CODE_W   (CODE_W),
        .GAP_TICKS(GAP_TICKS)
    ) u_code (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (load),
        .load_val (nv_rd_data),
        .step     (step),
        .allow    (allow),
        .code     (code)
    );

    trim_nv_seq #(
        .CODE_W    (CODE_W),
        .LOAD_TICKS(LOAD_TICKS)
    ) u_nv (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .commit     (commit && ready),
        .code       (code),
        .nv_busy    (nv_busy),
        .load       (load),
        .ready      (ready),
        .wr_busy    (wr_busy),
        .nv_wr_req  (nv_wr_req),
        .nv_wr_data (nv_wr_data)
    );

endmodule

// File: rtl/trim_pin_ctrl_chk.sv
module trim_pin_ctrl_chk #(
    parameter int unsigned CODE_W = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              cnt_en,
    input logic              nv_busy,
    input logic [CODE_W-1:0] code,
    input logic              ready,
    input logic              wr_busy,
    input logic              nv_wr_req,
    input logic [CODE_W-1:0] nv_wr_data
);

    localparam logic [CODE_W-1:0] TOP = '1;

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (code == '0 && !ready && !nv_wr_req)); // R1

    AST_CODE_STEP: assert property (@(posedge clk) disable iff (rst)
        ($past(ready) && code != $past(code)) |->
            (({1'b0, code} == {1'b0, $past(code)} + 1'b1) ||
             ({1'b0, $past(code)} == {1'b0, code} + 1'b1))); // R3

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (ready && code == TOP) |=> (code != '0)); // R6

    AST_EN_GATE: assert property (@(posedge clk) disable iff (rst)
        (ready && !cnt_en) |=> $stable(code)); // R7

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (nv_wr_req && !nv_busy) |=> (nv_wr_req && $stable(nv_wr_data))); // R9

    AST_REQ_READY: assert property (@(posedge clk) disable iff (rst)
        nv_wr_req |-> (ready && wr_busy)); // R11

    AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (rst)
        wr_busy |=> $stable(code)); // R11

endmodule

bind trim_pin_ctrl trim_pin_ctrl_chk #(
    .CODE_W(CODE_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cnt_en     (cnt_en),
    .nv_busy    (nv_busy),
    .code       (code),
    .ready      (ready),
    .wr_busy    (wr_busy),
    .nv_wr_req  (nv_wr_req),
    .nv_wr_data (nv_wr_data)
);

// File: tb/trim_pin_ctrl_tb_top.sv
module trim_pin_ctrl_tb_top;

    localparam int CODE_W  = 7;
    localparam int ACC     = 8;
    localparam int PRG     = 8;
    localparam int GAP     = 20;
    localparam int BOOT    = 5;
    localparam int WR_CLKS = 400;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick = 1'b0;
    logic              pin_lo = 1'b0;
    logic              pin_hi = 1'b0;
    logic              pin_prog = 1'b0;
    logic              cnt_en = 1'b1;
    logic [CODE_W-1:0] nv_mem = 7'd37;
    logic              nv_busy = 1'b0;
    logic [CODE_W-1:0] code;
    logic              ready;
    logic              wr_busy;
    logic              nv_wr_req;
    logic [CODE_W-1:0] nv_wr_data;

    int n_chk = 0;
    int n_fail = 0;
    int n_req = 0;
    int wcnt = 0;
    int phase = 0;

    always #4 clk = ~clk;

    always @(negedge clk) begin
        tick  <= (phase == 3);
        phase <= (phase + 1) % 4;
    end

    // storage model: busy for WR_CLKS cycles, then the cell takes the data
    always @(posedge clk) begin
        if (nv_wr_req && !nv_busy && wcnt == 0) begin
            nv_busy <= 1'b1;
            wcnt    <= WR_CLKS;
            n_req   <= n_req + 1;
        end else if (wcnt > 1) begin
            wcnt <= wcnt - 1;
        end else if (wcnt == 1) begin
            nv_mem  <= nv_wr_data;
            nv_busy <= 1'b0;
            wcnt    <= 0;
        end
    end

    trim_pin_ctrl #(
        .CODE_W      (CODE_W),
        .ACCEPT_TICKS(ACC),
        .PROG_TICKS  (PRG),
        .GAP_TICKS   (GAP),
        .LOAD_TICKS  (BOOT),
        .SYNC_STAGES (2)
    ) dut_i (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .pin_lo     (pin_lo),
        .pin_hi     (pin_hi),
        .pin_prog   (pin_prog),
        .cnt_en     (cnt_en),
        .nv_rd_data (nv_mem),
        .nv_busy    (nv_busy),
        .code       (code),
        .ready      (ready),
        .wr_busy    (wr_busy),
        .nv_wr_req  (nv_wr_req),
        .nv_wr_data (nv_wr_data)
    );

    function automatic int model_step(input int c, input bit inc);
        if (inc)
            return (c == 127) ? 127 : c + 1;
        else
            return (c == 0) ? 0 : c - 1;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n * 4) @(negedge clk);
    endtask

    // kind: 0 low, 1 high, 2 programming
    task automatic set_pin(input int kind);
        @(negedge clk);
        pin_lo   = (kind == 0);
        pin_hi   = (kind == 1) || (kind == 2);
        pin_prog = (kind == 2);
    endtask

    task automatic set_mid();
        @(negedge clk);
        pin_lo   = 1'b0;
        pin_hi   = 1'b0;
        pin_prog = 1'b0;
    endtask

    task automatic excur(input int kind, input int w);
        set_pin(kind);
        hold(w);
        set_mid();
        hold(25);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        hold(BOOT + 5);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int exp_code;
        int unsigned seed;
        seed = $urandom(32'd20240607);

        repeat (5) @(negedge clk);
        check("R1 code in reset", code, 0);
        check("R1 ready in reset", ready, 0);
        check("R1 no request in reset", nv_wr_req, 0);
        rst = 1'b0;
        hold(1);
        check("R2 not ready before boot interval", ready, 0);
        hold(BOOT + 4);
        check("R2 loaded code", code, 37);
        check("R2 ready after load", ready, 1);

        excur(0, 12);
        check("R3 low increments", code, 38);
        excur(1, 12);
        check("R3 high decrements", code, 37);

        excur(0, 4);
        check("R4 short low rejected", code, 37);
        excur(1, 4);
        check("R4 short high rejected", code, 37);

        set_pin(0);
        hold(12);
        set_pin(1);
        hold(12);
        set_mid();
        hold(25);
        check("R5 low then high without mid", code, 38);

        cnt_en = 1'b0;
        excur(0, 12);
        check("R7 enable low holds code", code, 38);
        cnt_en = 1'b1;

        set_pin(0);
        hold(10);
        set_mid();
        hold(2);
        set_pin(0);
        hold(10);
        set_mid();
        hold(25);
        check("R8 second count inside spacing ignored", code, 39);
        excur(0, 12);
        check("R8 count after spacing accepted", code, 40);

        set_pin(2);
        hold(12);
        set_mid();
        hold(2);
        check("R11 busy during write", wr_busy, 1);
        check("R9 write data", nv_wr_data, 40);
        excur(0, 12);
        check("R11 count ignored while busy", code, 40);
        for (int i = 0; i < 200 && wr_busy; i++) hold(1);
        check("R11 busy released", wr_busy, 0);
        check("R9 storage holds code", nv_mem, 40);
        check("R9 one request", n_req, 1);

        excur(2, 4);
        check("R10 short programming level", n_req, 1);

        excur(0, 12);
        check("R3 step after write", code, 41);
        do_reset();
        check("R2 reload of committed code", code, 40);

        nv_mem = 7'd126;
        do_reset();
        excur(0, 12);
        excur(0, 12);
        excur(0, 12);
        check("R6 saturate at 127", code, 127);
        nv_mem = 7'd1;
        do_reset();
        excur(1, 12);
        excur(1, 12);
        excur(1, 12);
        check("R6 saturate at 0", code, 0);

        nv_mem = 7'd64;
        do_reset();
        exp_code = 64;
        for (int i = 0; i < 40; i++) begin
            int  w;
            bit  lng;
            bit  inc;
            bit  en;
            lng = ($urandom % 2) == 1;
            inc = ($urandom % 2) == 1;
            en  = ($urandom % 5) != 0;
            w   = lng ? 11 + ($urandom % 5) : 1 + ($urandom % 4);
            cnt_en = en;
            set_pin(inc ? 0 : 1);
            hold(w);
            set_mid();
            hold(22 + ($urandom % 8));
            if (lng && en)
                exp_code = model_step(exp_code, inc);
            check(lng ? (en ? "R3 random long" : "R7 random disabled") : "R4 random short",
                  code, exp_code);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule